// File: doc/BRIEF.md
# Two-Port Mailbox Interrupt Flags

This block produces the mailbox interrupts for a memory shared by two ports, called left and right. Each port owns one interrupt flag, and only the opposite port can raise it. A port raises the other side's flag by writing to that side's mailbox word, which is one of the two highest addresses. The owning port acknowledges the flag by reading its own mailbox word with output enable active. The memory array itself is elsewhere. This block only observes each port's enable, write, output-enable and address signals on every clock and drives one active-low interrupt pin per port.

The right port's mailbox is the highest address, all ones (0xFFF for 12 address bits, 0x1FFF for 13). The left port's mailbox is the address one below it. The address width is a parameter, so both locations follow the memory depth.

Each flag is a small state machine with two states. FLAG_IDLE means no interrupt is pending and the pin is high. FLAG_PENDING means an interrupt is waiting and the pin is low. The transition *raise* (FLAG_IDLE to FLAG_PENDING) fires on a mailbox write from the opposite port. The transition *acknowledge* (FLAG_PENDING to FLAG_IDLE) fires on a mailbox read by the owner in a cycle with no raise. In every other cycle the machine *holds* its state. Reset forces both machines to FLAG_IDLE.

Top module: `mbox_irq`

## Requirements
- R1: While reset is low, and in the first cycle after it is released, both interrupt outputs are high (deasserted).
- R2: A cycle with l_en=1, l_we=1 and l_addr equal to all ones drives r_irq_n low from the next clock edge.
- R3: A cycle with r_en=1, r_we=1 and r_addr equal to all ones minus one drives l_irq_n low from the next clock edge.
- R4: A cycle with r_en=1, r_we=0, r_oe=1 and r_addr equal to all ones drives r_irq_n high from the next clock edge, provided R2's condition is not present in the same cycle.
- R5: A cycle with l_en=1, l_we=0, l_oe=1 and l_addr equal to all ones minus one drives l_irq_n high from the next clock edge, provided R3's condition is not present in the same cycle.
- R6: A port reading its own mailbox with its output enable low, or writing its own mailbox, leaves its interrupt unchanged.
- R7: Any access made with the port's enable low has no effect on either interrupt.
- R8: Accesses to any other address have no effect on either interrupt. This covers the neighbouring addresses, and also a port reading the opposite side's mailbox or writing its own.
- R9: When a raise and an acknowledge of the same flag fall in the same cycle, the raise wins and the flag is pending afterwards.
- R10: A pending interrupt stays low across any number of cycles until its acknowledge condition occurs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| l_en | input | 1 | Left port access enable, active high |
| l_we | input | 1 | Left port write (1) or read (0) |
| l_oe | input | 1 | Left port output enable, active high |
| l_addr | input | AW | Left port address |
| r_en | input | 1 | Right port access enable, active high |
| r_we | input | 1 | Right port write (1) or read (0) |
| r_oe | input | 1 | Right port output enable, active high |
| r_addr | input | AW | Right port address |
| l_irq_n | output | 1 | Left port interrupt, active low |
| r_irq_n | output | 1 | Right port interrupt, active low |

## Verification
Several rules are checked on every cycle by assertions: a mailbox write always leaves the opposite flag pending, the raise takes priority in a collision, a clean acknowledge always clears the flag, and a flag never moves without its own raise or acknowledge condition. The bench's scenarios are needed to show which specific accesses do not count as a trigger. These are reads with output enable low, disabled cycles, writes to a port's own mailbox, and the addresses just below the mailboxes. The scenarios also cover reset in the middle of a run while flags are pending, and long stretches where a flag must stay latched.

// File: rtl/mbox_pkg.sv
package mbox_pkg;

    typedef enum logic {
        FLAG_IDLE    = 1'b0,
        FLAG_PENDING = 1'b1
    } flag_state_e;

    typedef struct packed {
        logic en;
        logic we;
        logic oe;
    } port_ctl_t;

    localparam int NUM_PORTS = 2;
    localparam int PORT_LEFT = 0;
    localparam int PORT_RIGHT = 1;

endpackage

// File: rtl/mbox_port_decode.sv
module mbox_port_decode
    import mbox_pkg::*;
#(
    parameter int AW = 12,
    parameter bit RAISE_AT_TOP = 1'b1
) (
    input  port_ctl_t         ctl,
    input  logic [AW-1:0]     addr,
    output logic              raise_other,
    output logic              ack_own
);

    localparam logic [AW-1:0] TOP_ADDR  = {AW{1'b1}};
    localparam logic [AW-1:0] NEXT_ADDR = TOP_ADDR - 1'b1;

    logic [AW-1:0] raise_addr;
    logic [AW-1:0] ack_addr;

    generate
        if (RAISE_AT_TOP) begin : g_top_raise
            assign raise_addr = TOP_ADDR;
            assign ack_addr   = NEXT_ADDR;
        end else begin : g_next_raise
            assign raise_addr = NEXT_ADDR;
            assign ack_addr   = TOP_ADDR;
        end
    endgenerate

    logic is_write;
    logic is_read;

    always_comb begin
        is_write    = ctl.en && ctl.we;
        is_read     = ctl.en && !ctl.we && ctl.oe;
        raise_other = is_write && (addr == raise_addr);
        ack_own     = is_read && (addr == ack_addr);
    end

endmodule

// File: rtl/mbox_flag_fsm.sv
module mbox_flag_fsm
    import mbox_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic raise,
    input  logic ack,
    output logic irq_n
);

    flag_state_e state_q;
    flag_state_e state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= FLAG_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            FLAG_IDLE: begin
                if (raise) begin
                    state_d = FLAG_PENDING;
                end
            end
            FLAG_PENDING: begin
                if (ack && !raise) begin
                    state_d = FLAG_IDLE;
                end
            end
            default: state_d = FLAG_IDLE;
        endcase
    end

    always_comb begin
        unique case (state_q)
            FLAG_PENDING: irq_n = 1'b0;
            default:      irq_n = 1'b1;
        endcase
    end

endmodule

// File: rtl/mbox_irq.sv
module mbox_irq
    import mbox_pkg::*;
#(
    parameter int AW = 12
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          l_en,
    input  logic          l_we,
    input  logic          l_oe,
    input  logic [AW-1:0] l_addr,
    input  logic          r_en,
    input  logic          r_we,
    input  logic          r_oe,
    input  logic [AW-1:0] r_addr,
    output logic          l_irq_n,
    output logic          r_irq_n
);

    port_ctl_t     ctl     [NUM_PORTS];
    logic [AW-1:0] addr    [NUM_PORTS];
    logic          raise_o [NUM_PORTS];
    logic          ack_o   [NUM_PORTS];
    logic          irq_n_v [NUM_PORTS];

    assign ctl[PORT_LEFT]   = '{en: l_en, we: l_we, oe: l_oe};
    assign ctl[PORT_RIGHT]  = '{en: r_en, we: r_we, oe: r_oe};
    assign addr[PORT_LEFT]  = l_addr;
    assign addr[PORT_RIGHT] = r_addr;

    generate
        for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
            mbox_port_decode #(
                .AW          (AW),
                .RAISE_AT_TOP(p == PORT_LEFT)
            ) u_dec (
                .ctl        (ctl[p]),
                .addr       (addr[p]),
                .raise_other(raise_o[p]),
                .ack_own    (ack_o[p])
            );

            mbox_flag_fsm u_flag (
                .clk  (clk),
                .rst_n(rst_n),
                .raise(raise_o[NUM_PORTS-1-p]),
                .ack  (ack_o[p]),
                .irq_n(irq_n_v[p])
            );
        end
    endgenerate

    assign l_irq_n = irq_n_v[PORT_LEFT];
    assign r_irq_n = irq_n_v[PORT_RIGHT];

endmodule

// File: rtl/mbox_irq_chk.sv
module mbox_irq_chk #(
    parameter int AW = 12
) (
    input logic          clk,
    input logic          rst_n,
    input logic          l_en,
    input logic          l_we,
    input logic          l_oe,
    input logic [AW-1:0] l_addr,
    input logic          r_en,
    input logic          r_we,
    input logic          r_oe,
    input logic [AW-1:0] r_addr,
    input logic          l_irq_n,
    input logic          r_irq_n
);

    localparam logic [AW-1:0] HI = {AW{1'b1}};
    localparam logic [AW-1:0] LO = HI - 1'b1;

    logic l_wr_hi, r_wr_lo, r_rd_hi, l_rd_lo;
    assign l_wr_hi = l_en && l_we && (l_addr == HI);
    assign r_wr_lo = r_en && r_we && (r_addr == LO);
    assign r_rd_hi = r_en && !r_we && r_oe && (r_addr == HI);
    assign l_rd_lo = l_en && !l_we && l_oe && (l_addr == LO);

    p_reset_idle_r1: assert property (@(posedge clk)
        !rst_n |=> (l_irq_n && r_irq_n));

    p_raise_right_r2: assert property (@(posedge clk) disable iff (!rst_n)
        l_wr_hi |=> !r_irq_n);

    p_raise_left_r3: assert property (@(posedge clk) disable iff (!rst_n)
        r_wr_lo |=> !l_irq_n);

    p_ack_right_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (r_rd_hi && !l_wr_hi) |=> r_irq_n);

    p_ack_left_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (l_rd_lo && !r_wr_lo) |=> l_irq_n);

    p_collision_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (l_wr_hi && r_rd_hi) |=> !r_irq_n);

    p_hold_right_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (!r_irq_n && !r_rd_hi) |=> !r_irq_n);

    p_hold_left_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (!l_irq_n && !l_rd_lo) |=> !l_irq_n);

    p_quiet_right_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (r_irq_n && !l_wr_hi) |=> r_irq_n);

    p_quiet_left_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (l_irq_n && !r_wr_lo) |=> l_irq_n);

endmodule

bind mbox_irq mbox_irq_chk #(.AW(AW)) u_chk (.*);

// File: tb/mbox_irq_tb.sv
`timescale 1ns/1ps
module mbox_irq_tb;

    localparam int AW = 12;
    localparam logic [AW-1:0] HI = {AW{1'b1}};
    localparam logic [AW-1:0] LO = HI - 1'b1;
    localparam logic [AW-1:0] LO2 = HI - 2'd2;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic l_en = 0, l_we = 0, l_oe = 0;
    logic r_en = 0, r_we = 0, r_oe = 0;
    logic [AW-1:0] l_addr = '0, r_addr = '0;
    logic l_irq_n, r_irq_n;

    int checks = 0;
    int errors = 0;
    string cur_req = "R1";
    bit m_l = 1'b0, m_r = 1'b0;

    always #2 clk = ~clk;

    mbox_irq #(.AW(AW)) u_dut (
        .clk(clk), .rst_n(rst_n),
        .l_en(l_en), .l_we(l_we), .l_oe(l_oe), .l_addr(l_addr),
        .r_en(r_en), .r_we(r_we), .r_oe(r_oe), .r_addr(r_addr),
        .l_irq_n(l_irq_n), .r_irq_n(r_irq_n)
    );

    // Behavioural reference: pending bits per port, updated from port events.
    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_l <= 1'b0;
            m_r <= 1'b0;
        end else begin
            bit lw_hi, rw_lo, rr_hi, lr_lo;
            lw_hi = l_en && l_we && (int'(l_addr) == (1 << AW) - 1);
            rw_lo = r_en && r_we && (int'(r_addr) == (1 << AW) - 2);
            rr_hi = r_en && !r_we && r_oe && (int'(r_addr) == (1 << AW) - 1);
            lr_lo = l_en && !l_we && l_oe && (int'(l_addr) == (1 << AW) - 2);
            if (lw_hi) m_r <= 1'b1; else if (rr_hi) m_r <= 1'b0;
            if (rw_lo) m_l <= 1'b1; else if (lr_lo) m_l <= 1'b0;
        end
    end

    task automatic compare_model();
        checks++;
        if (l_irq_n !== !m_l || r_irq_n !== !m_r) begin
            errors++;
            $display("FAIL %s model: l_irq_n=%b r_irq_n=%b expected %b %b",
                     cur_req, l_irq_n, r_irq_n, !m_l, !m_r);
        end
    endtask

    task automatic expect_out(input logic el, input logic er, input string req);
        checks++;
        if (l_irq_n !== el || r_irq_n !== er) begin
            errors++;
            $display("FAIL %s: l_irq_n=%b r_irq_n=%b expected %b %b",
                     req, l_irq_n, r_irq_n, el, er);
        end
    endtask

    task automatic cyc(input logic le, lw, lo, input logic [AW-1:0] la,
                       input logic re, rw, ro, input logic [AW-1:0] ra);
        l_en = le; l_we = lw; l_oe = lo; l_addr = la;
        r_en = re; r_we = rw; r_oe = ro; r_addr = ra;
        @(posedge clk);
        @(negedge clk);
        compare_model();
        l_en = 0; l_we = 0; l_oe = 0;
        r_en = 0; r_we = 0; r_oe = 0;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) cyc(0, 0, 0, '0, 0, 0, 0, '0);
    endtask

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    initial begin
        #100000;
        errors++;
        $display("FAIL watchdog: run did not finish, actual=hung expected=done");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        expect_out(1, 1, "R1");
        rst_n = 1'b1;
        @(negedge clk);
        expect_out(1, 1, "R1");

        cur_req = "R2";
        cyc(1, 1, 0, HI, 0, 0, 0, '0);
        expect_out(1, 0, "R2");

        cur_req = "R10";
        idle(5);
        expect_out(1, 0, "R10");

        cur_req = "R6";
        cyc(0, 0, 0, '0, 1, 0, 0, HI);
        cyc(0, 0, 0, '0, 1, 1, 0, HI);
        expect_out(1, 0, "R6");

        cur_req = "R7";
        cyc(0, 0, 0, '0, 0, 0, 1, HI);
        expect_out(1, 0, "R7");

        cur_req = "R8";
        cyc(0, 0, 0, '0, 1, 0, 1, LO);
        cyc(0, 0, 0, '0, 1, 0, 1, LO2);
        expect_out(1, 0, "R8");

        cur_req = "R4";
        cyc(0, 0, 0, '0, 1, 0, 1, HI);
        expect_out(1, 1, "R4");

        cur_req = "R3";
        cyc(0, 0, 0, '0, 1, 1, 0, LO);
        expect_out(0, 1, "R3");

        cur_req = "R8";
        cyc(1, 1, 0, LO, 1, 1, 0, LO2);
        cyc(1, 0, 1, HI, 1, 1, 0, HI);
        cyc(1, 1, 0, LO2, 0, 0, 0, '0);
        expect_out(0, 1, "R8");

        cur_req = "R6";
        cyc(1, 0, 0, LO, 0, 0, 0, '0);
        cyc(1, 1, 0, LO, 0, 0, 0, '0);
        expect_out(0, 1, "R6");

        cur_req = "R5";
        cyc(1, 0, 1, LO, 0, 0, 0, '0);
        expect_out(1, 1, "R5");

        cur_req = "R7";
        cyc(0, 1, 0, HI, 0, 1, 0, LO);
        expect_out(1, 1, "R7");

        cur_req = "R9";
        cyc(1, 1, 0, HI, 1, 0, 1, HI);
        expect_out(1, 0, "R9");
        cyc(1, 1, 0, HI, 1, 0, 1, HI);
        expect_out(1, 0, "R9");
        cyc(1, 0, 1, LO, 1, 1, 0, LO);
        expect_out(0, 0, "R9");

        cur_req = "R1";
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        expect_out(1, 1, "R1");
        rst_n = 1'b1;
        cyc(0, 0, 0, '0, 0, 0, 0, '0);
        expect_out(1, 1, "R1");

        cur_req = "R2";
        cyc(1, 1, 0, HI, 1, 1, 0, LO);
        expect_out(0, 0, "R2");
        cur_req = "R4";
        cyc(1, 0, 1, LO, 1, 0, 1, HI);
        expect_out(1, 1, "R4");
        idle(2);

        finish_run();
    end

endmodule